// File: doc/BRIEF.md
# Status Register Write Guard

This block keeps the status byte of a serial memory and decides, request by request, whether a write may go ahead. The byte holds four things: a hardware-lock enable bit, a two-bit protected-zone code, the write-enable latch and a busy flag. The lock enable bit and the zone code are modelled as plain flops that keep their value through every event except reset.

The surrounding frame decoder reports the following events: latch set, latch clear, a decoded status-write byte within a frame, and array byte-write requests with a 13-bit address. It also drives the chip-select level and a busy flag from the programming engine. In return the guard gives a combinational allow for each array write and a one-cycle allow pulse when a status write is committed. A status write is held pending until chip select rises. If the hardware lock becomes active before that rise, the pending write is cancelled. Once the write has committed, the lock pin has no further effect on it.

Top module: `wp_status_guard`

## Requirements
- R1: `status` reads {lock enable, 3'b000, zone[1:0], latch, busy} at bit positions 7, 6..4, 3..2, 1 and 0. Bit 0 follows the `busy` input in the same cycle, and bits 6..4 are always 0.
- R2: After reset, `status` reads 0x00: the latch is clear, the lock enable is 0 and the zone code is 00.
- R3: A `wel_set` pulse sets the latch from the next cycle and a `wel_clr` pulse clears it. If both arrive in the same cycle, the clear wins. Both are ignored while `busy` is 1.
- R4: The cycle after `busy` falls, the latch reads 0. This takes priority over a set in the same cycle.
- R5: The zone code decides which array addresses are refused. Code 00 protects nothing. Code 01 protects 0x1800..0x1FFF, code 10 protects 0x1000..0x1FFF, and code 11 protects every address.
- R6: `arr_wr_ok` is 1 only when `arr_wr_req` is 1, the latch is set, `busy` is 0 and the address lies outside the protected zone. It is combinational with the request.
- R7: A status write changes only bits 7, 3 and 2, copied from the data byte. The new value becomes visible the cycle after the commit cycle. The commit cycle is the first cycle with `cs_n` high after a low, and `sr_wr_ok` pulses in that cycle. Outside a commit, bits 7, 3 and 2 hold their value.
- R8: The hardware lock is active while `wp_n` is 0 and bit 7 is 1. While it is active, a status write request is ignored. When bit 7 is 0, `wp_n` has no effect.
- R9: If the lock becomes active while a status write is pending and `cs_n` is still low, the write is dropped. A lock that appears after the commit leaves the committed value unchanged.
- R10: A status write request is accepted only if the latch is set and `busy` is 0 in the request cycle.
- R11: A status write request made while `cs_n` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wp_n | input | 1 | Write-protect pin, low requests the lock |
| cs_n | input | 1 | Frame select, low during a frame |
| wel_set | input | 1 | Latch set event |
| wel_clr | input | 1 | Latch clear event |
| busy | input | 1 | Programming cycle in progress |
| sr_wr_req | input | 1 | Status write byte decoded this cycle |
| sr_wr_data | input | 8 | Status write data byte |
| arr_wr_req | input | 1 | Array byte write request |
| arr_addr | input | 13 | Array byte address |
| status | output | 8 | Readable status byte |
| arr_wr_ok | output | 1 | Array write allowed |
| sr_wr_ok | output | 1 | Status write committed this cycle |

## Verification
Results fall due at three different points. `arr_wr_ok` and status bit 0 follow their inputs within the same cycle. `sr_wr_ok` rises in the first cycle in which `cs_n` reads high. The latch, the zone bits and the lock enable show a change one edge after the event that caused it. The bench changes inputs just after each rising edge and compares every output on the falling edge against a behavioural model. The model advances its state only at rising edges, so same-cycle and next-cycle results are each checked in the cycle they are due. Directed checks on literal status values cover the abort window, the lock, the refused requests and the zone boundaries.

// File: rtl/wpg_pkg.sv
package wpg_pkg;
   localparam int unsigned SR_W = 8;
   localparam int unsigned POS_LOCK_EN = 7;
   localparam int unsigned POS_ZONE_HI = 3;
   localparam int unsigned POS_ZONE_LO = 2;
   localparam int unsigned POS_LATCH   = 1;
   localparam int unsigned POS_BUSY    = 0;

   typedef enum logic [1:0] {
      ZONE_NONE    = 2'b00,
      ZONE_QUARTER = 2'b01,
      ZONE_HALF    = 2'b10,
      ZONE_ALL     = 2'b11
   } zone_e;

   typedef struct packed {
      logic  lock_en;
      zone_e zone;
   } nv_bits_t;
endpackage

// File: rtl/wpg_zone_decode.sv
module wpg_zone_decode
   import wpg_pkg::*;
#(
   parameter int unsigned ADDR_W = 13
) (
   input  zone_e             zone,
   input  logic [ADDR_W-1:0] addr,
   output logic              in_zone
);
   localparam int unsigned TOP = ADDR_W - 1;

   generate
      if (ADDR_W < 2) begin : g_bad
         $error("wpg_zone_decode: ADDR_W must be at least 2");
      end
   endgenerate

   always_comb begin
      unique case (zone)
         ZONE_NONE:    in_zone = 1'b0;
         ZONE_QUARTER: in_zone = addr[TOP] & addr[TOP-1];
         ZONE_HALF:    in_zone = addr[TOP];
         default:      in_zone = 1'b1;
      endcase
   end
endmodule

// File: rtl/wpg_latch.sv
module wpg_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic set_ev,
   input  logic clr_ev,
   input  logic busy,
   output logic latch
);
   logic busy_q;
   logic busy_fall;

   assign busy_fall = busy_q & ~busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         latch  <= 1'b0;
      end else begin
         busy_q <= busy;
         if (busy_fall)
            latch <= 1'b0;
         else if (!busy && clr_ev)
            latch <= 1'b0;
         else if (!busy && set_ev)
            latch <= 1'b1;
      end
   end
endmodule

// File: rtl/wpg_sr_commit.sv
module wpg_sr_commit
   import wpg_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              wp_n,
   input  logic              latch,
   input  logic              busy,
   input  logic              req,
   input  logic [SR_W-1:0]   data,
   output nv_bits_t          nv,
   output logic              commit
);
   logic     cs_q;
   logic     pend;
   nv_bits_t pend_val;
   logic     lock;
   logic     cs_rise;

   assign lock    = ~wp_n & nv.lock_en;
   assign cs_rise = cs_n & ~cs_q;
   assign commit  = cs_rise & pend & ~lock;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_q     <= 1'b1;
         pend     <= 1'b0;
         pend_val <= '0;
         nv       <= '0;
      end else begin
         cs_q <= cs_n;
         if (commit)
            nv <= pend_val;
         if (cs_rise) begin
            pend <= 1'b0;
         end else if (pend && !cs_n && lock) begin
            pend <= 1'b0;
         end else if (req && !cs_n && latch && !busy && !lock) begin
            pend              <= 1'b1;
            pend_val.lock_en  <= data[POS_LOCK_EN];
            pend_val.zone     <= zone_e'(data[POS_ZONE_HI:POS_ZONE_LO]);
         end
      end
   end
endmodule

// File: rtl/wp_status_guard.sv
module wp_status_guard
   import wpg_pkg::*;
#(
   parameter int unsigned ADDR_W = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wp_n,
   input  logic              cs_n,
   input  logic              wel_set,
   input  logic              wel_clr,
   input  logic              busy,
   input  logic              sr_wr_req,
   input  logic [7:0]        sr_wr_data,
   input  logic              arr_wr_req,
   input  logic [ADDR_W-1:0] arr_addr,
   output logic [7:0]        status,
   output logic              arr_wr_ok,
   output logic              sr_wr_ok
);
   nv_bits_t nv;
   logic     latch;
   logic     in_zone;

   wpg_latch u_latch (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_ev (wel_set),
      .clr_ev (wel_clr),
      .busy   (busy),
      .latch  (latch)
   );

   wpg_sr_commit u_commit (
      .clk    (clk),
      .rst_n  (rst_n),
      .cs_n   (cs_n),
      .wp_n   (wp_n),
      .latch  (latch),
      .busy   (busy),
      .req    (sr_wr_req),
      .data   (sr_wr_data),
      .nv     (nv),
      .commit (sr_wr_ok)
   );

   wpg_zone_decode #(.ADDR_W(ADDR_W)) u_zone (
      .zone    (nv.zone),
      .addr    (arr_addr),
      .in_zone (in_zone)
   );

   always_comb begin
      status              = '0;
      status[POS_LOCK_EN] = nv.lock_en;
      status[POS_ZONE_HI:POS_ZONE_LO] = nv.zone;
      status[POS_LATCH]   = latch;
      status[POS_BUSY]    = busy;
   end

   assign arr_wr_ok = arr_wr_req & latch & ~busy & ~in_zone;
endmodule

// File: rtl/wpg_checker.sv
module wpg_checker #(
   parameter int unsigned ADDR_W = 13
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wp_n,
   input logic              busy,
   input logic              arr_wr_req,
   input logic [ADDR_W-1:0] arr_addr,
   input logic [7:0]        status,
   input logic              arr_wr_ok,
   input logic              sr_wr_ok
);
   assert_unused_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
      status[6:4] == 3'b000);

   assert_busy_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |=> !status[1]);

   assert_full_zone_R5: assert property (@(posedge clk) disable iff (!rst_n)
      arr_wr_ok |-> status[3:2] != 2'b11);

   assert_array_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
      arr_wr_ok |-> (arr_wr_req && status[1] && !status[0]));

   assert_nv_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !sr_wr_ok |=> $stable({status[7], status[3:2]}));

   assert_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
      sr_wr_ok |-> !(!wp_n && status[7]));
endmodule

bind wp_status_guard wpg_checker #(.ADDR_W(ADDR_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wp_n       (wp_n),
   .busy       (busy),
   .arr_wr_req (arr_wr_req),
   .arr_addr   (arr_addr),
   .status     (status),
   .arr_wr_ok  (arr_wr_ok),
   .sr_wr_ok   (sr_wr_ok)
);

// File: tb/wp_status_guard_tb.sv
module wp_status_guard_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wp_n = 1'b1;
   logic        cs_n = 1'b1;
   logic        wel_set = 1'b0;
   logic        wel_clr = 1'b0;
   logic        busy = 1'b0;
   logic        sr_wr_req = 1'b0;
   logic [7:0]  sr_wr_data = 8'h00;
   logic        arr_wr_req = 1'b0;
   logic [12:0] arr_addr = '0;
   logic [7:0]  status;
   logic        arr_wr_ok;
   logic        sr_wr_ok;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   // reference model state
   int m_lock_en = 0, m_zone = 0, m_latch = 0, m_pend = 0, m_pdata = 0;
   int m_busy_q = 0, m_cs_q = 1;

   always #2.5 clk = ~clk;

   wp_status_guard u_dut (
      .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .cs_n(cs_n),
      .wel_set(wel_set), .wel_clr(wel_clr), .busy(busy),
      .sr_wr_req(sr_wr_req), .sr_wr_data(sr_wr_data),
      .arr_wr_req(arr_wr_req), .arr_addr(arr_addr),
      .status(status), .arr_wr_ok(arr_wr_ok), .sr_wr_ok(sr_wr_ok)
   );

   function automatic bit zone_hit(int zone, int addr);
      if (zone == 0) return 0;
      if (zone == 1) return addr >= 'h1800;
      if (zone == 2) return addr >= 'h1000;
      return 1;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_lock_en = 0; m_zone = 0; m_latch = 0; m_pend = 0; m_pdata = 0;
         m_busy_q = 0; m_cs_q = 1;
      end else begin
         bit lock, rise, fall;
         lock = !wp_n && m_lock_en != 0;
         rise = cs_n && m_cs_q == 0;
         fall = m_busy_q != 0 && !busy;
         if (rise && m_pend != 0 && !lock) begin
            m_lock_en = (m_pdata >> 7) & 1;
            m_zone    = (m_pdata >> 2) & 3;
         end
         if (rise) m_pend = 0;
         else if (m_pend != 0 && !cs_n && lock) m_pend = 0;
         else if (sr_wr_req && !cs_n && m_latch != 0 && !busy && !lock) begin
            m_pend = 1; m_pdata = sr_wr_data;
         end
         if (fall) m_latch = 0;
         else if (!busy && wel_clr) m_latch = 0;
         else if (!busy && wel_set) m_latch = 1;
         m_busy_q = busy;
         m_cs_q = cs_n;
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         int exp_st;
         bit exp_arr, exp_sr;
         exp_st = (m_lock_en << 7) | (m_zone << 2) | (m_latch << 1) | (busy ? 1 : 0);
         exp_arr = arr_wr_req && m_latch != 0 && !busy && !zone_hit(m_zone, arr_addr);
         exp_sr = cs_n && m_cs_q == 0 && m_pend != 0 && !(!wp_n && m_lock_en != 0);
         n_chk += 3;
         if (status !== exp_st[7:0]) begin
            n_bad++;
            $display("FAIL R1 status: actual %h expected %h", status, exp_st[7:0]);
         end
         if (arr_wr_ok !== exp_arr) begin
            n_bad++;
            $display("FAIL R6 arr_wr_ok: actual %b expected %b", arr_wr_ok, exp_arr);
         end
         if (sr_wr_ok !== exp_sr) begin
            n_bad++;
            $display("FAIL R7 sr_wr_ok: actual %b expected %b", sr_wr_ok, exp_sr);
         end
      end
   end

   task automatic tick(int n = 1);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic chk_status(logic [7:0] exp, string tag);
      @(negedge clk);
      n_chk++;
      if (status !== exp) begin
         n_bad++;
         $display("FAIL %s status: actual %h expected %h", tag, status, exp);
      end
      #1;
   endtask

   task automatic chk_arr(logic [12:0] a, logic exp, string tag);
      arr_wr_req = 1'b1;
      arr_addr = a;
      @(negedge clk);
      n_chk++;
      if (arr_wr_ok !== exp) begin
         n_bad++;
         $display("FAIL %s arr_wr_ok @%h: actual %b expected %b", tag, a, arr_wr_ok, exp);
      end
      tick();
      arr_wr_req = 1'b0;
   endtask

   task automatic pulse_set();
      wel_set = 1'b1; tick(); wel_set = 1'b0; tick();
   endtask

   task automatic pulse_clr();
      wel_clr = 1'b1; tick(); wel_clr = 1'b0; tick();
   endtask

   task automatic sr_write(logic [7:0] d);
      cs_n = 1'b0; tick();
      sr_wr_req = 1'b1; sr_wr_data = d; tick();
      sr_wr_req = 1'b0; tick();
      cs_n = 1'b1; tick(2);
   endtask

   initial begin
      tick(4);
      rst_n = 1'b1;
      tick();
      chk_status(8'h00, "R2");
      chk_arr(13'h0000, 1'b0, "R6");
      pulse_set();
      chk_status(8'h02, "R3");
      chk_arr(13'h1FFF, 1'b1, "R5");
      sr_write(8'hFF);
      chk_status(8'h8E, "R7");
      chk_arr(13'h0000, 1'b0, "R5");
      busy = 1'b1; wel_clr = 1'b1; tick(); wel_clr = 1'b0;
      chk_status(8'h8F, "R3");
      busy = 1'b0; tick();
      chk_status(8'h8C, "R4");
      wp_n = 1'b0;
      pulse_set();
      sr_write(8'h00);
      chk_status(8'h8E, "R8");
      wp_n = 1'b1;
      sr_write(8'h84);
      chk_status(8'h86, "R7");
      chk_arr(13'h17FF, 1'b1, "R5");
      chk_arr(13'h1800, 1'b0, "R5");
      // lock appears while the write is pending
      cs_n = 1'b0; tick();
      sr_wr_req = 1'b1; sr_wr_data = 8'h00; tick();
      sr_wr_req = 1'b0; wp_n = 1'b0; tick();
      wp_n = 1'b1; tick();
      cs_n = 1'b1; tick(2);
      chk_status(8'h86, "R9");
      // lock appears after the commit
      sr_write(8'h88);
      wp_n = 1'b0; tick(2);
      chk_status(8'h8A, "R9");
      wp_n = 1'b1;
      pulse_clr();
      sr_write(8'h00);
      chk_status(8'h88, "R10");
      pulse_set();
      sr_wr_req = 1'b1; sr_wr_data = 8'h00; tick();
      sr_wr_req = 1'b0; tick();
      cs_n = 1'b0; tick(); cs_n = 1'b1; tick(2);
      chk_status(8'h8A, "R11");
      chk_arr(13'h0FFF, 1'b1, "R5");
      chk_arr(13'h1000, 1'b0, "R5");
      sr_write(8'h00);
      chk_status(8'h02, "R7");
      wp_n = 1'b0;
      sr_write(8'h04);
      chk_status(8'h06, "R8");
      wp_n = 1'b1;
      tick(3);
      done = 1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
         end
      join_any
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule